// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Register with Output Latch

This block turns a serial bit stream into a wide parallel word. Each device in the chain has a shift stage and a storage stage of the same width. The shift stage takes one bit per rising edge of its own clock, and the storage stage takes a copy of the whole shift stage on the rising edge of a second, independent clock. A caller can therefore load a complete new word while the old word is still shown on the outputs. The new word then appears on all outputs at once, on a single latch edge.

An active-low clear empties the shift stage straight away and leaves the storage stage as it is. An active-low output enable releases the parallel bus to high impedance. A serial tap on the last shift bit of each device feeds the next device, so `NUM_DEV` devices act as one long register of `NUM_DEV*DEV_WIDTH` bits. The tap of the final device leaves the block as the cascade output.

Top module: `srl_chain`

## Requirements
- R1: On each rising edge of `shiftClk` while `clrN` is high, `serialIn` enters overall bit 0 and every shift bit k moves to bit k+1. Overall bit d*DEV_WIDTH+i is bit i of device d, where bit 0 is the entry bit of that device and bit DEV_WIDTH-1 is its last bit.
- R2: On each rising edge of `latchClk`, the storage register copies every shift bit in parallel. With `oeN` low, `parOut[k]` equals stored bit k.
- R3: `cascadeOut` always equals the current last shift bit (overall bit NUM_DEV*DEV_WIDTH-1). It does not depend on the storage register.
- R4: While `clrN` is low, every shift bit is 0 at once, with no clock edge needed, and rising `shiftClk` edges do not shift.
- R5: A clear leaves the storage register unchanged. The zeros reach `parOut` only after the next `latchClk` rising edge.
- R6: When `shiftClk` and `latchClk` rise together, the storage register captures the shift value from before that edge, so it lags the shift stage by one pulse.
- R7: While `oeN` is high, every `parOut` bit is released (high impedance). While `oeN` is low, `parOut` drives the stored word.
- R8: `oeN` has no effect on `cascadeOut` or on the shift and storage contents.
- R9: The tap of device d feeds the serial input of device d+1. After NUM_DEV*DEV_WIDTH shifts, the first bit shifted in sits in the highest bit of the last device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Rising-edge clock of the shift stage |
| latchClk | input | 1 | Rising-edge clock of the storage stage |
| clrN | input | 1 | Active-low asynchronous clear of the shift stage only |
| oeN | input | 1 | Active-low enable of the parallel bus |
| serialIn | input | 1 | Serial data into device 0 |
| parOut | output | NUM_DEV*DEV_WIDTH | Tri-state parallel word from the storage registers |
| cascadeOut | output | 1 | Last shift bit of the last device |

## Verification
The case that is hardest to bring about from the ports is a clear that falls between two latch edges and is held across a shift edge. The bus must keep showing the old stored word while the cascade tap already reads zero, and shift edges that arrive during the clear must do nothing. Directed steps hold `clrN` low around a `shiftClk` pulse and check the tap and the bus before any latch edge. Random steps mix isolated clear pulses with tied-clock, shift-only, latch-only and released-bus cycles. On the bench the bus is pulled high, so a released bus reads as all ones, and the bench checks this against stored words that are not all ones.

// File: rtl/srl_pkg.sv
package srl_pkg;
  // Strobes from the control decode to each datapath device
  typedef struct packed {
    logic clearShift; // empty the shift stage now
    logic driveBus;   // parallel bus is driven
  } srlStrobes_t;
endpackage

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_pkg::*;
(
  input  logic        clrN,
  input  logic        oeN,
  output srlStrobes_t strobes
);
  always_comb begin
    strobes.clearShift = !clrN;
    strobes.driveBus   = !oeN;
  end
endmodule

// File: rtl/srl_stage.sv
module srl_stage
  import srl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  srlStrobes_t      strobes,
  input  logic             serialIn,
  output logic [WIDTH-1:0] storeQ,
  output logic             tapOut
);
  logic             clearNow;
  logic [WIDTH-1:0] shiftQ;
  logic             shiftPrimed;
  logic             latchPrimed;

  assign clearNow = strobes.clearShift;

  // Shift stage: bit 0 takes the serial input, the clear overrides any edge
  always_ff @(posedge shiftClk or posedge clearNow) begin
    if (clearNow) shiftQ <= '0;
    else          shiftQ <= {shiftQ[WIDTH-2:0], serialIn};
  end

  // Storage stage: parallel copy on its own clock, untouched by the clear
  always_ff @(posedge latchClk) begin
    storeQ <= shiftQ;
  end

  assign tapOut = shiftQ[WIDTH-1];

  // Flags marking that a previous edge exists for the $past checks
  always_ff @(posedge shiftClk or posedge clearNow) begin
    if (clearNow) shiftPrimed <= 1'b0;
    else          shiftPrimed <= 1'b1;
  end

  always_ff @(posedge latchClk or posedge clearNow) begin
    if (clearNow) latchPrimed <= 1'b0;
    else          latchPrimed <= 1'b1;
  end

  // R1: bits move one place up on each shift edge
  a_r1_shift_move: assert property (@(posedge shiftClk) disable iff (clearNow)
    shiftPrimed |-> shiftQ[WIDTH-1:1] == $past(shiftQ[WIDTH-2:0]))
    else $error("a_r1_shift_move");

  // R1 and R9: the entry bit is the serial input, which is the previous device's tap
  a_r1_entry: assert property (@(posedge shiftClk) disable iff (clearNow)
    shiftPrimed |-> shiftQ[0] == $past(serialIn))
    else $error("a_r1_entry");

  // R2 and R6: storage holds the shift value seen at the previous latch edge
  a_r2_capture: assert property (@(posedge latchClk) disable iff (clearNow)
    latchPrimed |-> storeQ == $past(shiftQ))
    else $error("a_r2_capture");

  // R4: a held clear keeps the shift stage empty through shift edges
  always @(negedge shiftClk) begin
    if (clearNow) begin
      a_r4_clear_hold: assert (shiftQ == '0) else $error("a_r4_clear_hold");
    end
  end
endmodule

// File: rtl/srl_chain.sv
module srl_chain
  import srl_pkg::*;
#(
  parameter int NUM_DEV   = 2,
  parameter int DEV_WIDTH = 8
) (
  input  logic                           shiftClk,
  input  logic                           latchClk,
  input  logic                           clrN,
  input  logic                           oeN,
  input  logic                           serialIn,
  output logic [NUM_DEV*DEV_WIDTH-1:0]   parOut,
  output logic                           cascadeOut
);
  localparam int TOTAL = NUM_DEV * DEV_WIDTH;

  srlStrobes_t        strobes;
  logic [NUM_DEV:0]   link;
  logic [TOTAL-1:0]   storeAll;

  srl_ctrl u_ctrl (
    .clrN    (clrN),
    .oeN     (oeN),
    .strobes (strobes)
  );

  assign link[0] = serialIn;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    srl_stage #(.WIDTH(DEV_WIDTH)) u_stage (
      .shiftClk (shiftClk),
      .latchClk (latchClk),
      .strobes  (strobes),
      .serialIn (link[d]),
      .storeQ   (storeAll[d*DEV_WIDTH +: DEV_WIDTH]),
      .tapOut   (link[d+1])
    );
  end

  assign cascadeOut = link[NUM_DEV];
  assign parOut     = strobes.driveBus ? storeAll : 'z;
endmodule

// File: tb/tb_srl_chain.sv
module tb_srl_chain;
  localparam int NUM_DEV   = 2;
  localparam int DEV_WIDTH = 8;
  localparam int TOTAL     = NUM_DEV * DEV_WIDTH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic shiftClk = 1'b0, latchClk = 1'b0, clrN = 1'b0, oeN = 1'b1, serialIn = 1'b0;
  wire  [TOTAL-1:0] parOut;
  logic cascadeOut;

  for (genvar i = 0; i < TOTAL; i++) begin : g_pull
    pullup (parOut[i]);
  end

  srl_chain #(.NUM_DEV(NUM_DEV), .DEV_WIDTH(DEV_WIDTH)) dut (
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .clrN     (clrN),
    .oeN      (oeN),
    .serialIn (serialIn),
    .parOut   (parOut),
    .cascadeOut (cascadeOut)
  );

  int total = 0;
  int bad   = 0;
  logic [TOTAL-1:0] mShift = '0;
  logic [TOTAL-1:0] mStore = '0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [TOTAL-1:0] busExp(input logic oe, input logic [TOTAL-1:0] st);
    return oe ? {TOTAL{1'b1}} : st;   // released bus reads pulled high
  endfunction

  // One step: optional clear pulse, then optional shift and latch edges together
  task automatic step(input bit sh, input bit la, input bit sIn, input bit oe, input bit clr);
    logic [TOTAL-1:0] pre;
    serialIn = sIn;
    oeN = oe;
    if (clr) begin
      clrN = 1'b0; #1;
      mShift = '0;
      chk("R4 clear immediate", {{(TOTAL-1){1'b0}}, cascadeOut}, '0);
      chk("R5 store kept on clear", parOut, busExp(oe, mStore));
      clrN = 1'b1;
    end
    #1;
    pre = mShift;
    if (la) mStore = pre;
    if (sh) mShift = {pre[TOTAL-2:0], sIn};
    shiftClk = sh; latchClk = la;
    #2;
    shiftClk = 1'b0; latchClk = 1'b0;
    #2;
    chk(oe ? "R8 tap with bus released" : "R3 tap", {{(TOTAL-1){1'b0}}, cascadeOut},
        {{(TOTAL-1){1'b0}}, mShift[TOTAL-1]});
    chk(oe ? "R7 bus released" : (sh && la) ? "R6 tied clocks" : la ? "R2 latch" : "R1 shift",
        parOut, busExp(oe, mStore));
  endtask

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd20240607);
    #3;
    chk("R4 initial tap", {{(TOTAL-1){1'b0}}, cascadeOut}, '0);
    chk("R7 initial release", parOut, {TOTAL{1'b1}});
    clrN = 1'b1;
    #2;
    step(0, 1, 0, 0, 0);                 // R2: store the empty shift stage

    // R9: first bit ends at the top of the last device
    step(1, 0, 1, 0, 0);
    for (int k = 1; k < TOTAL; k++) step(1, 0, 0, 0, 0);
    chk("R9 first bit at top tap", {{(TOTAL-1){1'b0}}, cascadeOut}, {{(TOTAL-1){1'b0}}, 1'b1});
    step(0, 1, 0, 0, 0);
    chk("R9 first bit at top bus", parOut, {1'b1, {(TOTAL-1){1'b0}}});

    // R1 pattern, then R7 and R8 with bus released
    for (int k = 0; k < TOTAL; k++) step(1, 0, k[0] ^ k[2], 0, 0);
    step(0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 0);

    // R4 and R5: clear held across a shift edge, storage unchanged until latch
    clrN = 1'b0; #1;
    shiftClk = 1'b1; #2; shiftClk = 1'b0; #1;
    mShift = '0;
    chk("R4 clear holds over shift edge", {{(TOTAL-1){1'b0}}, cascadeOut}, '0);
    chk("R5 bus keeps old word", parOut, mStore);
    clrN = 1'b1; #2;
    step(0, 1, 0, 0, 0);
    chk("R5 zeros after latch", parOut, '0);

    // R6 tied clocks from a known state
    step(1, 1, 1, 0, 0);
    chk("R6 lag one pulse", parOut, '0);

    for (int n = 0; n < 400; n++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 2,
           ($urandom % 4) == 0, ($urandom % 29) == 0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule